// File: doc/BRIEF.md
# Time-Slot Window Pattern Checker

This block watches the receive side of a time-division multiplexed switch. Every cycle it may be given one byte, tagged with the number of the highway it came from and the time slot it occupies. The checker picks one highway. On that highway it monitors an inclusive, contiguous band of time slots. Each monitored byte is compared with a fixed expected byte. The result of each comparison appears as a one-cycle match or mismatch strobe. The number of differing bits is added to a bit-error counter that saturates at its maximum value.

A small write-only register port sets four things: the highway select, the lower slot bound, the upper slot bound and the expected byte. Writes first land in pending registers. The pending values, and the highway rate on `rate_sel`, are copied into the active configuration only at a frame-start strobe. This means the window never moves in the middle of a frame. The frame length is 32, 64 or 128 slots, depending on the rate. A bound past the end of the frame is pulled back to the last slot of the frame.

Top module: `slot_window_checker`

## Requirements
- R1: After reset, `match_o`, `mismatch_o` and `err_count` are 0, and the active configuration is highway 0, both bounds 0, expected byte 0x00 and rate 0 (32 slots).
- R2: Only bytes whose `in_hwy` equals the active highway select are monitored. The select is written at address 0 and taken from bits 3:0; bits 7:4 are ignored.
- R3: Every slot from the lower bound to the upper bound, both included, is monitored. The lower bound is written at address 1 and the upper bound at address 2, each taken from bits 6:0 with bit 7 ignored.
- R4: When the lower and upper bounds are equal, exactly that one slot is monitored.
- R5: When the written lower bound is greater than the written upper bound, no slot is monitored.
- R6: The frame length is 32 slots for rate 0, 64 for rate 1 and 128 for rate 2; rate 3 acts as rate 2. A bound above the last slot of the frame is clamped to the last slot, and slots beyond the frame length are never monitored.
- R7: One cycle after a monitored byte, `match_o` pulses if the byte equals the expected byte (written at address 3), and `mismatch_o` pulses otherwise. Both stay low after a cycle with no monitored byte.
- R8: One cycle after a monitored byte, `err_count` has grown by the number of bits in which the byte differs from the expected byte. The count stops at 255 and is cleared only by reset.
- R9: Register writes and `rate_sel` take effect only when `frame_start` is high. A byte in the same cycle as `frame_start` still uses the old configuration. A write in the same cycle as `frame_start` waits for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Frame-start strobe; loads the active configuration |
| rate_sel | input | 2 | Highway rate code, sampled at frame start |
| in_valid | input | 1 | A highway byte is present |
| in_hwy | input | 4 | Highway number of the byte |
| in_slot | input | 7 | Time slot of the byte |
| in_data | input | 8 | Highway byte |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0 highway, 1 lower, 2 upper, 3 expected byte) |
| cfg_wdata | input | 8 | Register write data |
| match_o | output | 1 | Monitored byte equalled the expected byte |
| mismatch_o | output | 1 | Monitored byte differed from the expected byte |
| err_count | output | 8 | Saturating count of differing bits |

## Verification
The hardest case to reach from the ports is a pair of bounds that both lie past the end of a short frame. Clamping turns such a pair into a single-slot window on the last slot, except when the written lower bound is above the written upper bound; then the window must stay empty. Directed writes put both bounds above 100 and then apply frame starts at each rate, checking the slots just inside and just outside the clamped edge. Random writes, frame starts and bytes then mix configuration changes with traffic. Some of these writes land in the same cycle as a frame start, which tests the deferred loading.

// File: rtl/swc_pkg.sv
package swc_pkg;
   typedef enum logic [1:0] {
      REG_HWY = 2'd0,
      REG_LO  = 2'd1,
      REG_HI  = 2'd2,
      REG_PAT = 2'd3
   } swc_reg_e;
endpackage

// File: rtl/swc_cfg.sv
module swc_cfg #(
   parameter int HWY_W  = 4,
   parameter int SLOT_W = 7,
   parameter int DATA_W = 8,
   parameter int RATE_W = 2,
   parameter int REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [HWY_W-1:0]  act_hwy,
   output logic [SLOT_W-1:0] act_lo,
   output logic [SLOT_W-1:0] act_hi,
   output logic [DATA_W-1:0] act_pat,
   output logic [RATE_W-1:0] act_rate
);
   import swc_pkg::*;

   logic [HWY_W-1:0]  pend_hwy;
   logic [SLOT_W-1:0] pend_lo, pend_hi;
   logic [DATA_W-1:0] pend_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_hwy <= '0;
         pend_lo  <= '0;
         pend_hi  <= '0;
         pend_pat <= '0;
      end else if (cfg_we) begin
         case (swc_reg_e'(cfg_addr))
            REG_HWY: pend_hwy <= cfg_wdata[HWY_W-1:0];
            REG_LO:  pend_lo  <= cfg_wdata[SLOT_W-1:0];
            REG_HI:  pend_hi  <= cfg_wdata[SLOT_W-1:0];
            default: pend_pat <= cfg_wdata[DATA_W-1:0];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_hwy  <= '0;
         act_lo   <= '0;
         act_hi   <= '0;
         act_pat  <= '0;
         act_rate <= '0;
      end else if (frame_start) begin
         act_hwy  <= pend_hwy;
         act_lo   <= pend_lo;
         act_hi   <= pend_hi;
         act_pat  <= pend_pat;
         act_rate <= rate_sel;
      end
   end
endmodule

// File: rtl/swc_window.sv
module swc_window #(
   parameter int HWY_W      = 4,
   parameter int SLOT_W     = 7,
   parameter int RATE_W     = 2,
   parameter int BASE_SLOTS = 32,
   parameter int N_RATES    = 3
) (
   input  logic              in_valid,
   input  logic [HWY_W-1:0]  in_hwy,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic [HWY_W-1:0]  act_hwy,
   input  logic [SLOT_W-1:0] act_lo,
   input  logic [SLOT_W-1:0] act_hi,
   input  logic [RATE_W-1:0] act_rate,
   output logic              hit
);
   localparam int MAX_RATE = N_RATES - 1;

   logic [SLOT_W-1:0] last_tab [N_RATES];
   logic [SLOT_W-1:0] last_slot, lo_eff, hi_eff;

   for (genvar r = 0; r < N_RATES; r++) begin : g_rate
      assign last_tab[r] = SLOT_W'((BASE_SLOTS << r) - 1);
   end

   always_comb begin
      last_slot = last_tab[MAX_RATE];
      for (int r = 0; r < MAX_RATE; r++) begin
         if (int'(act_rate) == r) last_slot = last_tab[r];
      end
   end

   assign lo_eff = (act_lo > last_slot) ? last_slot : act_lo;
   assign hi_eff = (act_hi > last_slot) ? last_slot : act_hi;

   assign hit = in_valid && (in_hwy == act_hwy) && (act_lo <= act_hi) &&
                (in_slot <= last_slot) && (in_slot >= lo_eff) && (in_slot <= hi_eff);
endmodule

// File: rtl/swc_compare.sv
module swc_compare #(
   parameter int DATA_W = 8,
   parameter int PC_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] pat,
   output logic [PC_W-1:0]   ones,
   output logic              match_q,
   output logic              mismatch_q
);
   logic [DATA_W-1:0] diff;

   assign diff = data ^ pat;

   always_comb begin
      ones = '0;
      for (int b = 0; b < DATA_W; b++) ones = ones + PC_W'(diff[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q    <= 1'b0;
         mismatch_q <= 1'b0;
      end else begin
         match_q    <= hit && (diff == '0);
         mismatch_q <= hit && (diff != '0);
      end
   end
endmodule

// File: rtl/swc_errcnt.sv
module swc_errcnt #(
   parameter int CNT_W = 8,
   parameter int PC_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [PC_W-1:0]  inc,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W:0] sum;

   assign sum = {1'b0, count} + (CNT_W + 1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (hit)   count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
   end
endmodule

// File: rtl/slot_window_checker.sv
module slot_window_checker #(
   parameter int N_HWY      = 16,
   parameter int SLOT_W     = 7,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int REG_W      = 8,
   parameter int BASE_SLOTS = 32,
   parameter int N_RATES    = 3,
   localparam int HWY_W     = $clog2(N_HWY),
   localparam int RATE_W    = $clog2(N_RATES + 1),
   localparam int PC_W      = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              in_valid,
   input  logic [HWY_W-1:0]  in_hwy,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              match_o,
   output logic              mismatch_o,
   output logic [CNT_W-1:0]  err_count
);
   if ((BASE_SLOTS << (N_RATES - 1)) > (1 << SLOT_W)) begin : g_bad_slots
      $error("slot index too narrow for the longest frame");
   end
   if (DATA_W > REG_W || SLOT_W >= REG_W || HWY_W > REG_W) begin : g_bad_reg
      $error("register port narrower than a configuration field");
   end
   if (PC_W > CNT_W) begin : g_bad_cnt
      $error("error counter narrower than one byte's bit count");
   end

   logic [HWY_W-1:0]  act_hwy;
   logic [SLOT_W-1:0] act_lo, act_hi;
   logic [DATA_W-1:0] act_pat;
   logic [RATE_W-1:0] act_rate;
   logic              hit;
   logic [PC_W-1:0]   ones;

   swc_cfg #(.HWY_W(HWY_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W),
             .RATE_W(RATE_W), .REG_W(REG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rate_sel(rate_sel),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .act_hwy(act_hwy), .act_lo(act_lo), .act_hi(act_hi),
      .act_pat(act_pat), .act_rate(act_rate)
   );

   swc_window #(.HWY_W(HWY_W), .SLOT_W(SLOT_W), .RATE_W(RATE_W),
                .BASE_SLOTS(BASE_SLOTS), .N_RATES(N_RATES)) u_win (
      .in_valid(in_valid), .in_hwy(in_hwy), .in_slot(in_slot),
      .act_hwy(act_hwy), .act_lo(act_lo), .act_hi(act_hi),
      .act_rate(act_rate), .hit(hit)
   );

   swc_compare #(.DATA_W(DATA_W), .PC_W(PC_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .hit(hit), .data(in_data), .pat(act_pat),
      .ones(ones), .match_q(match_o), .mismatch_q(mismatch_o)
   );

   swc_errcnt #(.CNT_W(CNT_W), .PC_W(PC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(hit), .inc(ones), .count(err_count)
   );
endmodule

// File: rtl/swc_props.sv
module swc_props #(
   parameter int HWY_W  = 4,
   parameter int SLOT_W = 7,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              in_valid,
   input logic [HWY_W-1:0]  in_hwy,
   input logic [HWY_W-1:0]  act_hwy,
   input logic [SLOT_W-1:0] act_lo,
   input logic [SLOT_W-1:0] act_hi,
   input logic              match_o,
   input logic              mismatch_o,
   input logic [CNT_W-1:0]  err_count
);
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(match_o && mismatch_o));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!match_o && !mismatch_o));

   assert_other_hwy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_hwy != act_hwy) |=> (!match_o && !mismatch_o));

   assert_reversed_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_lo > act_hi) |=> (!match_o && !mismatch_o));

   assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == '1) |=> (err_count == '1));

   assert_count_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != '1) |=> (err_count >= $past(err_count)));

   assert_match_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (err_count == $past(err_count)));

   assert_window_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(act_lo) && $stable(act_hi) && $stable(act_hwy)));
endmodule

bind slot_window_checker swc_props #(.HWY_W(HWY_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_props (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
   .in_hwy(in_hwy), .act_hwy(act_hwy), .act_lo(act_lo), .act_hi(act_hi),
   .match_o(match_o), .mismatch_o(mismatch_o), .err_count(err_count)
);

// File: tb/sim_slot_window_checker.sv
module sim_slot_window_checker;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       frame_start;
   logic [1:0] rate_sel;
   logic       in_valid;
   logic [3:0] in_hwy;
   logic [6:0] in_slot;
   logic [7:0] in_data;
   logic       cfg_we;
   logic [1:0] cfg_addr;
   logic [7:0] cfg_wdata;
   logic       match_o, mismatch_o;
   logic [7:0] err_count;

   always #5 clk = ~clk;

   slot_window_checker u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rate_sel(rate_sel),
      .in_valid(in_valid), .in_hwy(in_hwy), .in_slot(in_slot), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .match_o(match_o), .mismatch_o(mismatch_o), .err_count(err_count)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [3:0] p_hwy, a_hwy;
   logic [6:0] p_lo, p_hi, a_lo, a_hi;
   logic [7:0] p_pat, a_pat;
   logic [1:0] a_rate;
   int         m_cnt;

   function automatic int pop8(logic [7:0] v);
      int n = 0;
      for (int b = 0; b < 8; b++) n += v[b];
      return n;
   endfunction

   function automatic int last_of(logic [1:0] r);
      return (r >= 2) ? 127 : ((32 << r) - 1);
   endfunction

   function automatic bit monitored(logic [3:0] h, logic [6:0] s);
      int l, lo, hi;
      if (h != a_hwy) return 1'b0;
      if (a_lo > a_hi) return 1'b0;
      l  = last_of(a_rate);
      lo = (a_lo > l) ? l : a_lo;
      hi = (a_hi > l) ? l : a_hi;
      return (s <= l) && (s >= lo) && (s <= hi);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_pend(logic [1:0] a, logic [7:0] d);
      case (a)
         2'd0: p_hwy = d[3:0];
         2'd1: p_lo  = d[6:0];
         2'd2: p_hi  = d[6:0];
         default: p_pat = d;
      endcase
   endtask

   task automatic do_reset();
      rst_n = 1'b0; frame_start = 0; rate_sel = 0; in_valid = 0; in_hwy = 0;
      in_slot = 0; in_data = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
      p_hwy = 0; p_lo = 0; p_hi = 0; p_pat = 0;
      a_hwy = 0; a_lo = 0; a_hi = 0; a_pat = 0; a_rate = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({match_o, mismatch_o, err_count} == 10'd0, "R1 reset outputs",
          int'({match_o, mismatch_o, err_count}), 0);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      model_pend(a, d);
   endtask

   task automatic fs(logic [1:0] r, bit with_wr = 0, logic [1:0] a = 0, logic [7:0] d = 0);
      @(negedge clk);
      frame_start = 1; rate_sel = r;
      if (with_wr) begin cfg_we = 1; cfg_addr = a; cfg_wdata = d; end
      @(negedge clk);
      frame_start = 0; cfg_we = 0;
      a_hwy = p_hwy; a_lo = p_lo; a_hi = p_hi; a_pat = p_pat; a_rate = r;
      if (with_wr) model_pend(a, d);
   endtask

   task automatic send(logic [3:0] h, logic [6:0] s, logic [7:0] d, string req);
      bit em, emm;
      int act, exp;
      @(negedge clk);
      in_valid = 1; in_hwy = h; in_slot = s; in_data = d;
      em  = monitored(h, s) && (d == a_pat);
      emm = monitored(h, s) && (d != a_pat);
      if (monitored(h, s)) begin
         m_cnt += pop8(d ^ a_pat);
         if (m_cnt > 255) m_cnt = 255;
      end
      @(negedge clk);
      in_valid = 0;
      act = int'({match_o, mismatch_o, err_count});
      exp = int'({em, emm, 8'(m_cnt)});
      chk(act == exp, req, act, exp);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();
      send(4'd0, 7'd0, 8'h00, "R1 reset window slot0 hwy0");
      send(4'd0, 7'd1, 8'h00, "R1 reset window slot1 outside");

      wr(2'd0, 8'hF5); wr(2'd1, 8'h83); wr(2'd2, 8'h85); wr(2'd3, 8'hA5);
      send(4'd5, 7'd4, 8'hA5, "R9 writes pending before frame start");
      fs(2'd0);
      send(4'd5, 7'd2, 8'hA5, "R3 below lower bound");
      send(4'd5, 7'd3, 8'hA5, "R3 lower bound included");
      send(4'd5, 7'd4, 8'h5A, "R8 eight differing bits");
      send(4'd5, 7'd5, 8'hA4, "R3 upper bound included");
      send(4'd5, 7'd6, 8'hA5, "R3 above upper bound");
      send(4'd4, 7'd4, 8'hA5, "R2 other highway ignored");

      wr(2'd1, 8'd7); wr(2'd2, 8'd7); fs(2'd0);
      send(4'd5, 7'd6, 8'hA5, "R4 single slot below");
      send(4'd5, 7'd7, 8'hA7, "R4 single slot hit");
      send(4'd5, 7'd8, 8'hA5, "R4 single slot above");

      wr(2'd1, 8'd9); wr(2'd2, 8'd8); fs(2'd0);
      send(4'd5, 7'd8, 8'hA5, "R5 reversed bounds slot8");
      send(4'd5, 7'd9, 8'hA5, "R5 reversed bounds slot9");

      wr(2'd1, 8'd100); wr(2'd2, 8'd120); fs(2'd0);
      send(4'd5, 7'd31, 8'hA5, "R6 clamp to slot31 rate0");
      send(4'd5, 7'd30, 8'hA5, "R6 slot30 outside clamp");
      send(4'd5, 7'd100, 8'hA5, "R6 slot beyond 32-slot frame");
      fs(2'd1);
      send(4'd5, 7'd63, 8'hA5, "R6 clamp to slot63 rate1");
      send(4'd5, 7'd64, 8'hA5, "R6 slot beyond 64-slot frame");
      fs(2'd3);
      send(4'd5, 7'd100, 8'hA5, "R6 rate3 acts as 128 slots");
      send(4'd5, 7'd99, 8'hA5, "R6 rate3 below lower bound");
      wr(2'd1, 8'd120); wr(2'd2, 8'd100); fs(2'd0);
      send(4'd5, 7'd31, 8'hA5, "R5 reversed bounds beyond frame");

      wr(2'd1, 8'd0); wr(2'd2, 8'd10); fs(2'd0);
      fs(2'd0, 1'b1, 2'd3, 8'h3C);
      send(4'd5, 7'd2, 8'hA5, "R9 write with frame start deferred");
      fs(2'd0);
      send(4'd5, 7'd2, 8'h3C, "R9 write applied next frame start");

      for (int i = 0; i < 40; i++)
         send(4'd5, 7'd3, 8'hC3, "R8 saturation at 255");

      do_reset();
      for (int i = 0; i < 1500; i++) begin
         int k = $urandom % 10;
         if (i == 750) do_reset();
         if (k == 0) begin
            logic [1:0] a = 2'($urandom);
            logic [7:0] d = (a == 2'd0) ? {4'($urandom), 2'b00, 2'($urandom)} : 8'($urandom);
            wr(a, d);
         end else if (k == 1) begin
            if ($urandom % 3 == 0) fs(2'($urandom), 1'b1, 2'($urandom), 8'($urandom));
            else fs(2'($urandom));
         end else begin
            logic [7:0] d = ($urandom % 2) ? a_pat : 8'($urandom);
            send(4'($urandom % 4), 7'($urandom), d, "R7 random traffic");
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule